// File: doc/BRIEF.md
# Partitioned gated-ring time-to-digital back end

This block is the digital side of a time-to-digital converter built around a gated ring oscillator of 47 inverting stages. It opens the oscillator gate when a start event arrives and closes it when the stop event arrives. While the gate is closed the ring is frozen and keeps its phase. No reset is applied to the ring between measurements, so the part of a step left over from one measurement carries into the next. After a programmable settling delay, the block strobes a sample of the frozen ring state. It then reports how many stage transitions happened while the gate was open.

The ring outputs are dealt out to seven measurement cells, and stage k goes to cell k mod 7. Inside each cell, only one of its stages can be changing at any moment, so the cell's local state always moves through a fixed order. Each cell keeps its own wrap counter and forms its own phase difference. The seven differences are added in a registered adder tree to give one 11-bit result. When the stop event does not arrive within the allowed window, the gate closes on its own and the result carries an overrange flag.

Top module: `gated_ring_tdc`

## Requirements
- R1: After reset, ring_en_o, valid_o and overrange_o are 0 and result_o is 0.
- R2: When start_i is sampled high with no measurement open, ring_en_o is high from the next cycle on. It stays high until the edge that samples stop_i high, so the window lasts exactly as many clocks as there are edges from the start edge to the stop edge.
- R3: A start_i pulse that arrives while a measurement is running or settling is ignored. The result still measures the window opened by the first start.
- R4: A stop_i pulse that arrives with no measurement open has no effect: ring_en_o stays 0 and no result is produced.
- R5: The ring is encoded with a phase p that counts transitions modulo 94. In that encoding, stage k is high exactly when ((p-k-1) mod 94) < 47, and the ring moves at most one transition per clock while it is enabled. Under that encoding, result_o equals the number of transitions made during the window, modulo 2048. The count is formed as the sum of seven independent cells, where cell c holds stages c, c+7, c+14 and so on.
- R6: The ring is never reset. Back-to-back measurements that start from any frozen phase each report only their own transition count.
- R7: If stop_i is not sampled within RUN_MAX (1500) enabled cycles, ring_en_o falls after exactly RUN_MAX cycles. The result is then RUN_MAX, with overrange_o high together with valid_o.
- R8: A stop sampled on the last allowed cycle closes the window normally: the result is RUN_MAX and overrange_o is 0.
- R9: valid_o is a single-cycle pulse that rises settle_i+4 edges after the edge that closes the window.
- R10: Between two consecutive samples, at most one stage inside any one cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start event, sampled on the clock |
| stop_i | input | 1 | Stop event, sampled on the clock |
| settle_i | input | SETTLE_W | Extra settling clocks before the sample strobe |
| ring_i | input | NSTAGE | Stage outputs of the gated ring |
| ring_en_o | output | 1 | Gate enable for the ring |
| result_o | output | RES_W | Transition count of the last window |
| valid_o | output | 1 | result_o is new this cycle |
| overrange_o | output | 1 | The window was closed by the timeout |

## Verification
The bench drives a ring model whose transitions follow ring_en_o and checks each result against the window length it chose. The windows cover one, two and three cycles, and lengths around 47 and 94 where cell wrap counters roll over. A cell that lost or double-counted a wrap would be off by a multiple of its phase count. Stray start or stop pulses are sent both mid-window and in the settling phase; a design that honoured them would restart the window or emit a phantom result. The bench also checks the timeout against a stop on the final allowed cycle. A design with an off-by-one run limit would report 1499 or 1501, or would raise the overrange flag wrongly. The latency of valid_o is checked for several settle_i values, so a strobe that fires early or late is caught.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SETTLE = 2'd2
  } tdc_state_e;

  // number of ring stages routed to cell c under round-robin assignment
  function automatic int cell_taps(input int nstage, input int ncell, input int c);
    return (nstage - c + ncell - 1) / ncell;
  endfunction
endpackage

// File: rtl/tdc_timing.sv
module tdc_timing
  import tdc_pkg::*;
#(
  parameter int RUN_MAX  = 1500,
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                ring_en_o,
  output logic                sample_o,
  output logic                ovr_o
);
  localparam int RUN_W = $clog2(RUN_MAX);

  tdc_state_e          state_q;
  logic [RUN_W-1:0]    run_cnt_q;
  logic [SETTLE_W-1:0] set_cnt_q;
  logic                ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      run_cnt_q <= '0;
      set_cnt_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_RUN;
          run_cnt_q <= '0;
          ovr_q     <= 1'b0;
        end
        ST_RUN: begin
          if (stop_i) begin
            state_q   <= ST_SETTLE;
            set_cnt_q <= '0;
          end else if (run_cnt_q == RUN_W'(RUN_MAX - 1)) begin
            state_q   <= ST_SETTLE;
            set_cnt_q <= '0;
            ovr_q     <= 1'b1;
          end else begin
            run_cnt_q <= run_cnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (set_cnt_q == settle_i) state_q <= ST_IDLE;
          else set_cnt_q <= set_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ring_en_o = (state_q == ST_RUN);
  assign sample_o  = (state_q == ST_SETTLE) && (set_cnt_q == settle_i);
  assign ovr_o     = ovr_q;

  AST_EN_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ring_en_o) |-> $past(start_i)); // R2
  AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_en_o |-> (run_cnt_q < RUN_W'(RUN_MAX))); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R9
  AST_STROBE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !ring_en_o); // R9
endmodule

// File: rtl/tdc_meas_cell.sv
module tdc_meas_cell #(
  parameter int M = 7,
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [M-1:0] stages_i,
  input  logic         sample_i,
  output logic [W-1:0] delta_o,
  output logic         valid_o
);
  localparam int PHASES = 2 * M;
  localparam int FW     = $clog2(PHASES + 1);
  localparam logic [W-1:0] PHASE_W = W'(PHASES);

  logic [M-1:0]  ring_q, ring_qq;
  logic [W-1:0]  coarse_q, coarse_now, total, prev_q;
  logic [FW-1:0] pop, fine;
  logic          last_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q  <= '0;
      ring_qq <= '0;
    end else begin
      ring_q  <= stages_i;
      ring_qq <= ring_q;
    end
  end

  // wrap marker: the last stage of the cell falls as the local phase returns to 0
  assign last_fall  = ring_qq[M-1] & ~ring_q[M-1];
  assign coarse_now = coarse_q + W'(last_fall);

  always_comb begin
    pop = '0;
    for (int j = 0; j < M; j++) pop = pop + FW'(ring_q[j]);
  end

  // rising half: first stage high; falling half: first stage already low
  always_comb begin
    if (ring_q[0])      fine = pop;
    else if (pop == '0) fine = '0;
    else                fine = FW'(PHASES) - pop;
  end

  assign total = coarse_now * PHASE_W + W'(fine);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      prev_q   <= '0;
      delta_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      coarse_q <= coarse_now;
      valid_o  <= sample_i;
      if (sample_i) begin
        prev_q  <= total;
        delta_o <= total - prev_q;
      end
    end
  end

  AST_ONE_MOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q ^ ring_qq) <= 1); // R10
  AST_FINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine < FW'(PHASES)); // R5
endmodule

// File: rtl/tdc_sum_tree.sv
module tdc_sum_tree #(
  parameter int N = 7,
  parameter int W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N*W-1:0] terms_i,
  input  logic           valid_i,
  input  logic           tag_i,
  output logic [W-1:0]   sum_o,
  output logic           valid_o,
  output logic           tag_o
);
  localparam int LEVELS = $clog2(N);
  localparam int LEAVES = 1 << LEVELS;

  logic [W-1:0]      node [1:2*LEAVES-1];
  logic [LEVELS-1:0] vld_pipe, tag_pipe;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[LEAVES+i] = terms_i[i*W +: W];
    end else begin : g_pad
      assign node[LEAVES+i] = '0;
    end
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_add
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) node[i] <= '0;
      else         node[i] <= node[2*i] + node[2*i+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_pipe <= '0;
      tag_pipe <= '0;
    end else begin
      vld_pipe <= {vld_pipe[LEVELS-2:0], valid_i};
      tag_pipe <= {tag_pipe[LEVELS-2:0], valid_i & tag_i};
    end
  end

  assign sum_o   = node[1];
  assign valid_o = vld_pipe[LEVELS-1];
  assign tag_o   = tag_pipe[LEVELS-1];

  AST_OUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_TAG_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o |-> valid_o); // R7
endmodule

// File: rtl/gated_ring_tdc.sv
module gated_ring_tdc
  import tdc_pkg::*;
#(
  parameter int NSTAGE   = 47,
  parameter int NCELL    = 7,
  parameter int RES_W    = 11,
  parameter int RUN_MAX  = 1500,
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [NSTAGE-1:0]   ring_i,
  output logic                ring_en_o,
  output logic [RES_W-1:0]    result_o,
  output logic                valid_o,
  output logic                overrange_o
);
  logic                   sample, ovr;
  logic [NCELL*RES_W-1:0] deltas;
  logic [NCELL-1:0]       cell_vld;

  tdc_timing #(.RUN_MAX(RUN_MAX), .SETTLE_W(SETTLE_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .settle_i (settle_i),
    .ring_en_o(ring_en_o),
    .sample_o (sample),
    .ovr_o    (ovr)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    localparam int M = cell_taps(NSTAGE, NCELL, c);
    logic [M-1:0]     taps;
    logic [RES_W-1:0] delta;
    for (genvar j = 0; j < M; j++) begin : g_tap
      assign taps[j] = ring_i[c + NCELL*j];
    end
    tdc_meas_cell #(.M(M), .W(RES_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stages_i(taps),
      .sample_i(sample),
      .delta_o (delta),
      .valid_o (cell_vld[c])
    );
    assign deltas[c*RES_W +: RES_W] = delta;
  end

  tdc_sum_tree #(.N(NCELL), .W(RES_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .terms_i(deltas),
    .valid_i(&cell_vld),
    .tag_i  (ovr),
    .sum_o  (result_o),
    .valid_o(valid_o),
    .tag_o  (overrange_o)
  );

  AST_CELLS_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cell_vld) |-> (&cell_vld)); // R5
  AST_NO_RESULT_WHILE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cell_vld) |-> !ring_en_o); // R2
endmodule

// File: tb/gated_ring_tdc_bench.sv
module gated_ring_tdc_bench;
  localparam int NSTAGE  = 47;
  localparam int RUN_MAX = 1500;
  localparam int LAT     = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [3:0]  settle_i = '0;
  logic [NSTAGE-1:0] ring_i;
  logic        ring_en_o, valid_o, overrange_o;
  logic [10:0] result_o;

  gated_ring_tdc u_gated_ring_tdc (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .settle_i(settle_i), .ring_i(ring_i), .ring_en_o(ring_en_o),
    .result_o(result_o), .valid_o(valid_o), .overrange_o(overrange_o)
  );

  always #2 clk = ~clk; // 250 MHz

  int checks = 0, bad = 0, cyc = 0, phase = 0, pushed = 0, seen = 0;
  bit done = 1'b0;
  int q_res[$], q_ovr[$], q_edge[$];

  always @(posedge clk) cyc <= cyc + 1;

  // ring model: one transition per clock while the gate is open
  always @(negedge clk) if (ring_en_o) phase <= (phase + 1) % (2*NSTAGE);
  always_comb
    for (int k = 0; k < NSTAGE; k++)
      ring_i[k] = (((phase - k - 1) % (2*NSTAGE) + 2*NSTAGE) % (2*NSTAGE)) < NSTAGE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) if (rst_ni && valid_o) begin
    seen++;
    if (q_res.size() == 0) check(1'b0, "R4 unexpected result", int'(result_o), -1);
    else begin
      int er, eo, ee;
      er = q_res.pop_front(); eo = q_ovr.pop_front(); ee = q_edge.pop_front();
      check(int'(result_o) == er, "R5 result", int'(result_o), er);
      check(int'(overrange_o) == eo, "R7 overrange", int'(overrange_o), eo);
      check(cyc == ee, "R9 latency", cyc, ee);
    end
  end

  // driver: one measurement of d cycles; extra pulses exercise R3
  task automatic measure(input int d, input int s, input bit do_stop,
                         input bit mid_start, input bit settle_start);
    int t0, n;
    @(negedge clk) settle_i = 4'(s); start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    t0 = cyc;
    check(ring_en_o == 1'b1, "R2 enable opens", int'(ring_en_o), 1);
    n = do_stop ? d : RUN_MAX;
    q_res.push_back(n % 2048); q_ovr.push_back(do_stop ? 0 : 1);
    q_edge.push_back(t0 + n + s + LAT); pushed++;
    for (int i = 1; i < d; i++) begin
      @(negedge clk);
      start_i = mid_start && (i == 1);
    end
    start_i = 1'b0;
    stop_i = do_stop;
    @(negedge clk) stop_i = 1'b0;
    if (do_stop) begin
      check(ring_en_o == 1'b0, "R2 enable closes", int'(ring_en_o), 0);
      start_i = settle_start;
      @(negedge clk) start_i = 1'b0;
    end
    while (q_res.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    check(1'b0, "watchdog", cyc, 100000);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ring_en_o == 0 && valid_o == 0 && overrange_o == 0 && result_o == 0,
          "R1 reset state", int'(result_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    measure(1, 0, 1, 0, 0);     // R5 shortest window
    measure(2, 3, 1, 0, 0);     // R9 settle 3
    measure(3, 0, 1, 0, 1);     // R3 start during settle
    measure(7, 15, 1, 0, 0);    // R9 longest settle
    measure(47, 1, 1, 1, 0);    // R3 start mid-window
    measure(94, 0, 1, 0, 0);    // R5 full ring period
    measure(95, 2, 1, 0, 0);    // R6 carries phase
    measure(500, 0, 1, 0, 0);   // R6 nonzero start phase
    measure(1499, 0, 1, 0, 0);  // R5 near limit
    measure(RUN_MAX, 0, 1, 0, 0); // R8 stop on last allowed cycle
    measure(10, 1, 0, 0, 0);    // R7 no stop: timeout
    measure(13, 0, 1, 0, 0);    // R6 after timeout
    // R4: stop with no measurement open
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    check(ring_en_o == 1'b0, "R4 enable stays low", int'(ring_en_o), 0);
    repeat (20) @(negedge clk);
    check(seen == pushed, "R4 result count", seen, pushed);
    report();
  end
endmodule